// File: doc/BRIEF.md
# Two-Word-Line Cache Controller with Selectable Write Policy

This block is a direct-mapped data cache controller placed between a processor port and a memory bus that carries one word per transfer. Every line holds two words and is always filled as a whole. A static parameter selects write-back or write-through behaviour. Both modes allocate a line on a write miss. The controller orders the bus work for each access: it writes back a modified victim, fills the line word by word, and sends write-through words. While a miss is being serviced it holds the processor stalled.

The processor raises `cpu_req` for one cycle with the operation, word address and write data. The controller ignores further requests until it pulses `cpu_done`. On a read, `cpu_rdata` is valid in the same cycle as `cpu_done`. On the bus, the controller holds `bus_req` with a stable address, direction and data until the memory side answers with `bus_ready`. A word moves at each clock edge where both signals are high. Four counters report hits, misses, words read from the bus and words written to it, so that bus bandwidth use can be measured.

Top module: `pair_line_cache`

## Requirements
- R1: A word address splits into bit 0 as the word within the line, the next log2(SETS) bits as the set index, and the remaining upper bits as the tag. A line fill reads the line-aligned word (offset 0) first and then word 1.
- R2: On a read hit, `cpu_done` pulses two cycles after the cycle in which `cpu_req` was sampled, with the addressed word on `cpu_rdata`. A read hit causes no bus transfer.
- R3: In write-back mode a write hit takes two controller cycles, one for the tag check and one for the data write, so `cpu_done` pulses three cycles after the request is sampled. It causes no bus transfer.
- R4: A miss whose victim line is invalid or unmodified costs exactly two bus reads of the new line before the access completes.
- R5: In write-back mode a miss whose victim line is modified first writes both victim words to memory at the victim's own address (word 0, then word 1). Only then does it perform the two fill reads, giving four transfers in total.
- R6: A write miss fills the line from memory before it applies the write. A later read of the same word returns the written value, including after the line has been evicted and refetched.
- R7: In write-through mode every write hit issues exactly one bus write of the written word at its address. A write miss issues two fill reads followed by that one write, and a miss never writes a victim back.
- R8: `cpu_stall` rises the cycle after a miss is detected and stays high until the access completes. It is low in the `cpu_done` cycle and never rises for a hit.
- R9: `cnt_hit` and `cnt_miss` count accesses found and not found in the cache. `cnt_bus_rd` and `cnt_bus_wr` count words moved in each direction on the bus.
- R10: After reset all lines are invalid, all counters are zero, and `cpu_stall`, `cpu_done` and `bus_req` are low.
- R11: While `bus_req` is high and `bus_ready` is low, the bus address, direction and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, sampled when the controller is idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_stall | output | 1 | High while a miss is serviced |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = word write to memory, 0 = word read |
| bus_addr | output | ADDR_W | Bus word address |
| bus_wdata | output | DATA_W | Word sent to memory |
| bus_ready | input | 1 | Memory accepts or supplies a word this cycle |
| bus_rdata | input | DATA_W | Word returned by memory |
| cnt_hit | output | CNT_W | Hit count |
| cnt_miss | output | CNT_W | Miss count |
| cnt_bus_rd | output | CNT_W | Words read over the bus |
| cnt_bus_wr | output | CNT_W | Words written over the bus |

## Verification
The hardest case to reach is a write-back miss that evicts a modified line while the memory side inserts wait states between words. Three conditions must line up: the set must hold a different tag, that line must have been written, and the bench must check both the order of the victim words and the written data they carry. The stimulus first writes a line, then reads a conflicting address in the same set. It then rereads the first address to confirm that the evicted data came back from memory. After that, a long pseudo-random run draws from only four tags per set, so dirty conflicts recur, while the memory model rotates its wait count through zero, one and two cycles for each word.

// File: rtl/plc_pkg.sv
// Shared definitions for the two-word-line cache controller.
// Assumes: only the controller FSM and its counters use these types.
package plc_pkg;

    // Controller states; the order of encodings carries no meaning.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_WRITE,
        ST_EVICT0,
        ST_EVICT1,
        ST_FILL0,
        ST_FILL1,
        ST_WT_WRITE
    } plc_state_e;

    // Positions of the event strobes in the counter bank.
    localparam int EV_HIT    = 0;
    localparam int EV_MISS   = 1;
    localparam int EV_BUS_RD = 2;
    localparam int EV_BUS_WR = 3;
    localparam int EV_NUM    = 4;

endpackage

// File: rtl/plc_store.sv
// Line storage: two data words, tag, valid and (write-back only) dirty per set.
// Reads are combinational on rd_idx. A word write port serves both fills and
// processor writes. The meta port marks a line valid and clean on a fill.
// Assumes: meta_we and dirty_set are never raised in the same cycle.
module plc_store #(
    parameter int DATA_W     = 32,
    parameter int TAG_W      = 6,
    parameter int SETS       = 8,
    parameter bit WRITE_BACK = 1'b1,
    localparam int IDX_W     = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_w0,
    output logic [DATA_W-1:0] rd_w1,
    input  logic              word_we,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic              word_sel,
    input  logic [DATA_W-1:0] word_data,
    input  logic              meta_we,
    input  logic [IDX_W-1:0]  meta_idx,
    input  logic [TAG_W-1:0]  meta_tag,
    input  logic              dirty_set
);

    logic [DATA_W-1:0] w0_q [SETS];
    logic [DATA_W-1:0] w1_q [SETS];
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [SETS-1:0]   valid_q;

    // Data words: written by fills and by processor write hits.
    always_ff @(posedge clk) begin
        if (word_we) begin
            if (word_sel) w1_q[word_idx] <= word_data;
            else          w0_q[word_idx] <= word_data;
        end
    end

    // Tag and valid bits: a fill installs the new tag and validates the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (meta_we) begin
            valid_q[meta_idx] <= 1'b1;
            tag_q[meta_idx]   <= meta_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_w0    = w0_q[rd_idx];
    assign rd_w1    = w1_q[rd_idx];

    generate
        if (WRITE_BACK) begin : g_dirty
            logic [SETS-1:0] dirty_q;
            // Dirty bits: cleared by a fill, set by a processor write.
            always_ff @(posedge clk) begin
                if (!rst_n)         dirty_q <= '0;
                else if (meta_we)   dirty_q[meta_idx] <= 1'b0;
                else if (dirty_set) dirty_q[word_idx] <= 1'b1;
            end
            assign rd_dirty = dirty_q[rd_idx];
        end else begin : g_clean
            logic unused_dirty_set;
            assign unused_dirty_set = dirty_set;
            assign rd_dirty = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/plc_counters.sv
// Bank of saturation-free event counters, one per strobe bit.
// Assumes: each strobe is a single-cycle pulse per event.
module plc_counters #(
    parameter int NUM   = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM-1:0]   ev,
    output logic [CNT_W-1:0] cnt [NUM]
);

    generate
        for (genvar g = 0; g < NUM; g++) begin : g_cnt
            logic [CNT_W-1:0] c_q;
            // Count one strobe bit.
            always_ff @(posedge clk) begin
                if (!rst_n)     c_q <= '0;
                else if (ev[g]) c_q <= c_q + 1'b1;
            end
            assign cnt[g] = c_q;
        end
    endgenerate

    // R9: a single access is never both a hit and a miss
    a_r9_hit_miss_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev[1:0]));

endmodule

// File: rtl/plc_ctrl.sv
// Access sequencer. It latches one processor request, checks the tag, and
// runs the eviction, fill and write-through bus steps one word at a time.
// Assumes: the processor issues no new request before cpu_done. The memory side
// completes a word at an edge where bus_req and bus_ready are both high.
module plc_ctrl
    import plc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int SETS       = 8,
    parameter bit WRITE_BACK = 1'b1,
    localparam int IDX_W     = $clog2(SETS),
    localparam int TAG_W     = ADDR_W - 1 - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              cpu_stall,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_valid,
    input  logic              rd_dirty,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [DATA_W-1:0] rd_w0,
    input  logic [DATA_W-1:0] rd_w1,
    output logic              word_we,
    output logic              word_sel,
    output logic [DATA_W-1:0] word_data,
    output logic              meta_we,
    output logic [TAG_W-1:0]  meta_tag,
    output logic              dirty_set,
    output logic [EV_NUM-1:0] ev
);

    plc_state_e        state;
    logic              req_we;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_data;
    logic              miss_q;

    logic [TAG_W-1:0]  req_tag;
    logic              req_sel;
    logic              hit;
    logic              xfer;

    assign rd_idx  = req_addr[IDX_W:1];
    assign req_tag = req_addr[ADDR_W-1:IDX_W+1];
    assign req_sel = req_addr[0];
    assign hit     = rd_valid && (rd_tag == req_tag);
    assign xfer    = bus_req && bus_ready;
    assign cpu_stall = miss_q;
    assign meta_tag  = req_tag;

    // Bus drive for the current state.
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            ST_EVICT0: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = {rd_tag, rd_idx, 1'b0}; bus_wdata = rd_w0;
            end
            ST_EVICT1: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = {rd_tag, rd_idx, 1'b1}; bus_wdata = rd_w1;
            end
            ST_FILL0: begin
                bus_req = 1'b1; bus_addr = {req_tag, rd_idx, 1'b0};
            end
            ST_FILL1: begin
                bus_req = 1'b1; bus_addr = {req_tag, rd_idx, 1'b1};
            end
            ST_WT_WRITE: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = req_addr; bus_wdata = req_data;
            end
            default: ;
        endcase
    end

    // Storage write strobes for fills and write hits.
    always_comb begin
        word_we   = 1'b0;
        word_sel  = 1'b0;
        word_data = bus_rdata;
        meta_we   = 1'b0;
        dirty_set = 1'b0;
        unique case (state)
            ST_FILL0: word_we = bus_ready;
            ST_FILL1: begin
                word_we  = bus_ready;
                word_sel = 1'b1;
                meta_we  = bus_ready;
            end
            ST_WRITE: begin
                word_we   = 1'b1;
                word_sel  = req_sel;
                word_data = req_data;
                dirty_set = WRITE_BACK;
            end
            default: ;
        endcase
    end

    // Event strobes for the counter bank.
    always_comb begin
        ev            = '0;
        ev[EV_HIT]    = (state == ST_COMPARE) && hit && !miss_q;
        ev[EV_MISS]   = (state == ST_COMPARE) && !hit;
        ev[EV_BUS_RD] = xfer && !bus_we;
        ev[EV_BUS_WR] = xfer && bus_we;
    end

    // State sequencing, request capture, completion and stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            req_we    <= 1'b0;
            req_addr  <= '0;
            req_data  <= '0;
            miss_q    <= 1'b0;
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            cpu_done <= 1'b0;
            unique case (state)
                ST_IDLE: if (cpu_req) begin
                    req_we   <= cpu_we;
                    req_addr <= cpu_addr;
                    req_data <= cpu_wdata;
                    state    <= ST_COMPARE;
                end
                ST_COMPARE: if (hit) begin
                    if (req_we) begin
                        state <= ST_WRITE;
                    end else begin
                        cpu_rdata <= req_sel ? rd_w1 : rd_w0;
                        cpu_done  <= 1'b1;
                        miss_q    <= 1'b0;
                        state     <= ST_IDLE;
                    end
                end else begin
                    miss_q <= 1'b1;
                    state  <= (WRITE_BACK && rd_valid && rd_dirty) ? ST_EVICT0 : ST_FILL0;
                end
                ST_WRITE: if (WRITE_BACK) begin
                    cpu_done <= 1'b1;
                    miss_q   <= 1'b0;
                    state    <= ST_IDLE;
                end else begin
                    state <= ST_WT_WRITE;
                end
                ST_EVICT0: if (bus_ready) state <= ST_EVICT1;
                ST_EVICT1: if (bus_ready) state <= ST_FILL0;
                ST_FILL0:  if (bus_ready) state <= ST_FILL1;
                ST_FILL1:  if (bus_ready) state <= ST_COMPARE;
                ST_WT_WRITE: if (bus_ready) begin
                    cpu_done <= 1'b1;
                    miss_q   <= 1'b0;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a read hit completes at the next edge with no bus activity
    a_r2_read_hit_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMPARE && hit && !req_we) |=> (cpu_done && !bus_req));

    // R11: an unanswered bus request keeps its address, direction and data
    a_r11_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R5: the second victim word is always followed by the first fill read
    a_r5_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVICT1 && bus_ready) |=> (bus_req && !bus_we && bus_addr[0] == 1'b0));

    // R8: stall is held throughout the fill of a line
    a_r8_stall_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL0 || state == ST_FILL1) |-> cpu_stall);

    generate
        if (WRITE_BACK) begin : g_wb_chk
            // R3: a write hit goes from tag check straight to the data write
            a_r3_write_hit_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
                (state == ST_COMPARE && hit && req_we) |=> (state == ST_WRITE ##1 cpu_done));
        end else begin : g_wt_chk
            // R7: every write in write-through mode is followed by one bus write
            a_r7_write_goes_to_bus: assert property (@(posedge clk) disable iff (!rst_n)
                (state == ST_WRITE) |=> (bus_req && bus_we && bus_addr == req_addr));
        end
    endgenerate

endmodule

// File: rtl/pair_line_cache.sv
// Top of the two-word-line direct-mapped cache controller. It joins the
// sequencer, the line storage and the event counters.
// Assumes: word addressing; WRITE_BACK fixed at build time.
module pair_line_cache
    import plc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int SETS       = 8,
    parameter int CNT_W      = 16,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              cpu_stall,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_bus_rd,
    output logic [CNT_W-1:0]  cnt_bus_wr
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - 1 - IDX_W;

    logic [IDX_W-1:0]  rd_idx;
    logic              rd_valid, rd_dirty;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_w0, rd_w1;
    logic              word_we, word_sel, meta_we, dirty_set;
    logic [DATA_W-1:0] word_data;
    logic [TAG_W-1:0]  meta_tag;
    logic [EV_NUM-1:0] ev;
    logic [CNT_W-1:0]  cnt [EV_NUM];

    plc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WRITE_BACK(WRITE_BACK)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_stall(cpu_stall),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
        .rd_w0(rd_w0), .rd_w1(rd_w1),
        .word_we(word_we), .word_sel(word_sel), .word_data(word_data),
        .meta_we(meta_we), .meta_tag(meta_tag), .dirty_set(dirty_set), .ev(ev)
    );

    plc_store #(
        .DATA_W(DATA_W), .TAG_W(TAG_W), .SETS(SETS), .WRITE_BACK(WRITE_BACK)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
        .rd_w0(rd_w0), .rd_w1(rd_w1),
        .word_we(word_we), .word_idx(rd_idx), .word_sel(word_sel), .word_data(word_data),
        .meta_we(meta_we), .meta_idx(rd_idx), .meta_tag(meta_tag), .dirty_set(dirty_set)
    );

    plc_counters #(.NUM(EV_NUM), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ev(ev), .cnt(cnt)
    );

    assign cnt_hit    = cnt[EV_HIT];
    assign cnt_miss   = cnt[EV_MISS];
    assign cnt_bus_rd = cnt[EV_BUS_RD];
    assign cnt_bus_wr = cnt[EV_BUS_WR];

endmodule

// File: tb/tb_pair_line_cache.sv
// Bench: one write-back and one write-through instance, each served by a
// behavioural memory with rotating wait states. A behavioural cache model
// predicts every bus transfer, the returned data, latency and stall.
module tb_pair_line_cache;

    localparam int CLK_P = 10;
    localparam int AW    = 10;
    localparam int DW    = 32;
    localparam int NS    = 8;
    localparam int MEMSZ = 1 << AW;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } xfer_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic          cpu_req [2];
    logic          cpu_we [2];
    logic [AW-1:0] cpu_addr [2];
    logic [DW-1:0] cpu_wdata [2];
    logic [DW-1:0] cpu_rdata [2];
    logic          cpu_done [2];
    logic          cpu_stall [2];
    logic          bus_req [2];
    logic          bus_we [2];
    logic [AW-1:0] bus_addr [2];
    logic [DW-1:0] bus_wdata [2];
    logic          bus_ready [2];
    logic [DW-1:0] bus_rdata [2];
    logic [15:0]   c_hit [2];
    logic [15:0]   c_miss [2];
    logic [15:0]   c_rd [2];
    logic [15:0]   c_wr [2];

    pair_line_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .WRITE_BACK(1'b1)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]), .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]),
        .cpu_rdata(cpu_rdata[0]), .cpu_done(cpu_done[0]), .cpu_stall(cpu_stall[0]),
        .bus_req(bus_req[0]), .bus_we(bus_we[0]), .bus_addr(bus_addr[0]), .bus_wdata(bus_wdata[0]),
        .bus_ready(bus_ready[0]), .bus_rdata(bus_rdata[0]),
        .cnt_hit(c_hit[0]), .cnt_miss(c_miss[0]), .cnt_bus_rd(c_rd[0]), .cnt_bus_wr(c_wr[0])
    );

    pair_line_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .WRITE_BACK(1'b0)) dut_wt (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]), .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]),
        .cpu_rdata(cpu_rdata[1]), .cpu_done(cpu_done[1]), .cpu_stall(cpu_stall[1]),
        .bus_req(bus_req[1]), .bus_we(bus_we[1]), .bus_addr(bus_addr[1]), .bus_wdata(bus_wdata[1]),
        .bus_ready(bus_ready[1]), .bus_rdata(bus_rdata[1]),
        .cnt_hit(c_hit[1]), .cnt_miss(c_miss[1]), .cnt_bus_rd(c_rd[1]), .cnt_bus_wr(c_wr[1])
    );

    int n_chk = 0;
    int n_err = 0;

    // Memory side state.
    logic [DW-1:0] mem [2][MEMSZ];
    int            wcnt [2];
    int            lat [2];
    xfer_t         log0 [$];
    xfer_t         log1 [$];

    // Reference cache model.
    bit            m_val [2][NS];
    bit            m_dty [2][NS];
    int            m_tag [2][NS];
    logic [DW-1:0] m_dat [2][NS][2];
    int            e_hit [2];
    int            e_miss [2];
    int            e_rd [2];
    int            e_wr [2];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory responder: decides ready at the falling edge; a word granted here
    // moves at the next rising edge, so it is logged and applied now.
    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                bus_ready[k] <= 1'b0;
                wcnt[k] = 0;
                lat[k]  = 0;
            end else if (bus_ready[k]) begin
                bus_ready[k] <= 1'b0;
            end else if (bus_req[k]) begin
                if (wcnt[k] >= lat[k]) begin
                    xfer_t x;
                    x.we = bus_we[k]; x.addr = bus_addr[k];
                    x.data = bus_we[k] ? bus_wdata[k] : mem[k][bus_addr[k]];
                    if (k == 0) log0.push_back(x); else log1.push_back(x);
                    bus_rdata[k] <= mem[k][bus_addr[k]];
                    if (bus_we[k]) mem[k][bus_addr[k]] = bus_wdata[k];
                    bus_ready[k] <= 1'b1;
                    wcnt[k] = 0;
                    lat[k]  = (lat[k] + 1) % 3;
                end else begin
                    wcnt[k]++;
                end
            end
        end
    end

    // One processor access on instance k (0 = write-back, 1 = write-through).
    task automatic do_op(input int k, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int idx, tag, ws, cyc, nlog;
        bit hit, seen_stall, stall_at_done, timeout;
        logic [AW-1:0] base;
        logic [DW-1:0] exp_rd;
        xfer_t expq [$];
        xfer_t x;
        idx  = int'(a[3:1]);
        tag  = int'(a[AW-1:4]);
        ws   = int'(a[0]);
        base = {a[AW-1:1], 1'b0};
        hit  = m_val[k][idx] && (m_tag[k][idx] == tag);
        if (!hit) begin
            if (k == 0 && m_val[k][idx] && m_dty[k][idx]) begin
                for (int w = 0; w < 2; w++) begin
                    x.we = 1'b1;
                    x.addr = AW'((m_tag[k][idx] << 4) | (idx << 1) | w);
                    x.data = m_dat[k][idx][w];
                    expq.push_back(x);
                end
            end
            for (int w = 0; w < 2; w++) begin
                x.we = 1'b0; x.addr = base | AW'(w); x.data = mem[k][base | AW'(w)];
                expq.push_back(x);
                m_dat[k][idx][w] = x.data;
            end
            m_val[k][idx] = 1'b1;
            m_tag[k][idx] = tag;
            m_dty[k][idx] = 1'b0;
            e_miss[k]++;
        end else begin
            e_hit[k]++;
        end
        if (we) begin
            m_dat[k][idx][ws] = d;
            if (k == 0) m_dty[k][idx] = 1'b1;
            else begin
                x.we = 1'b1; x.addr = a; x.data = d;
                expq.push_back(x);
            end
        end
        exp_rd = m_dat[k][idx][ws];
        foreach (expq[i]) begin
            if (expq[i].we) e_wr[k]++; else e_rd[k]++;
        end

        if (k == 0) log0.delete(); else log1.delete();
        @(negedge clk);
        cpu_req[k] = 1'b1; cpu_we[k] = we; cpu_addr[k] = a; cpu_wdata[k] = d;
        cyc = 0; seen_stall = 0; stall_at_done = 0; timeout = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) cpu_req[k] = 1'b0;
            if (cpu_done[k]) begin
                stall_at_done = cpu_stall[k];
                break;
            end
            if (cpu_stall[k]) seen_stall = 1;
            if (cyc > 200) begin timeout = 1; break; end
        end
        chk(!timeout, "R2", $sformatf("access completes addr=%0h", a), cyc, 0);

        nlog = (k == 0) ? log0.size() : log1.size();
        chk(nlog == expq.size(), hit ? "R2" : (k == 0 ? "R5" : "R4"),
            $sformatf("bus transfer count addr=%0h mode=%0d", a, k), nlog, expq.size());
        foreach (expq[i]) begin
            if (i < nlog) begin
                x = (k == 0) ? log0[i] : log1[i];
                chk(x.we == expq[i].we && x.addr == expq[i].addr, "R1",
                    $sformatf("transfer %0d dir/addr mode=%0d", i, k),
                    {x.we, x.addr}, {expq[i].we, expq[i].addr});
                if (expq[i].we)
                    chk(x.data == expq[i].data, k == 0 ? "R5" : "R7",
                        $sformatf("transfer %0d write data", i), x.data, expq[i].data);
            end
        end
        if (!we)
            chk(cpu_rdata[k] == exp_rd, "R6", $sformatf("read data addr=%0h mode=%0d", a, k),
                cpu_rdata[k], exp_rd);
        if (hit && !we)
            chk(cyc == 2, "R2", "read hit latency", cyc, 2);
        if (hit && we && k == 0)
            chk(cyc == 3, "R3", "write hit latency", cyc, 3);
        chk(seen_stall == !hit, "R8", $sformatf("stall during access addr=%0h", a), seen_stall, !hit);
        chk(stall_at_done == 0, "R8", "stall low at completion", stall_at_done, 0);
    endtask

    task automatic check_counters(input int k);
        chk(c_hit[k] == 16'(e_hit[k]), "R9", $sformatf("hit counter mode=%0d", k), c_hit[k], e_hit[k]);
        chk(c_miss[k] == 16'(e_miss[k]), "R9", $sformatf("miss counter mode=%0d", k), c_miss[k], e_miss[k]);
        chk(c_rd[k] == 16'(e_rd[k]), "R9", $sformatf("bus read counter mode=%0d", k), c_rd[k], e_rd[k]);
        chk(c_wr[k] == 16'(e_wr[k]), "R9", $sformatf("bus write counter mode=%0d", k), c_wr[k], e_wr[k]);
    endtask

    task automatic directed(input int k);
        do_op(k, 0, 10'h010, '0);            // R4 cold miss
        do_op(k, 0, 10'h011, '0);            // R2 read hit, word 1
        do_op(k, 1, 10'h010, 32'hCAFE0001);  // R3 / R7 write hit
        do_op(k, 0, 10'h010, '0);            // R6 written value visible
        do_op(k, 0, 10'h110, '0);            // R5 dirty victim (write-back)
        do_op(k, 0, 10'h010, '0);            // R6 refetched value
        do_op(k, 1, 10'h025, 32'hBEEF0002);  // R6 / R7 write miss allocates
        do_op(k, 0, 10'h025, '0);            // R6 read back
        do_op(k, 0, 10'h125, '0);            // R5 evict the allocated line
        do_op(k, 0, 10'h025, '0);            // R6 value survived eviction
    endtask

    task automatic random_run(input int k);
        logic [15:0] lf;
        lf = 16'hACE1 ^ 16'(k * 77);
        for (int i = 0; i < 120; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_op(k, lf[9], AW'(lf[5:0]), {lf, ~lf});
        end
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            cpu_req[k] = 0; cpu_we[k] = 0; cpu_addr[k] = '0; cpu_wdata[k] = '0;
            bus_rdata[k] = '0; bus_ready[k] = 0;
            e_hit[k] = 0; e_miss[k] = 0; e_rd[k] = 0; e_wr[k] = 0;
            for (int s = 0; s < NS; s++) begin
                m_val[k][s] = 0; m_dty[k][s] = 0; m_tag[k][s] = 0;
            end
            for (int a = 0; a < MEMSZ; a++) mem[k][a] = 32'hA000_0000 + 32'(a * 3) + 32'(k << 20);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(!cpu_stall[k] && !cpu_done[k] && !bus_req[k], "R10", "outputs idle after reset",
                {cpu_stall[k], cpu_done[k], bus_req[k]}, 0);
            chk(c_hit[k] == 0 && c_miss[k] == 0 && c_rd[k] == 0 && c_wr[k] == 0, "R10",
                "counters zero after reset", c_hit[k] + c_miss[k] + c_rd[k] + c_wr[k], 0);
        end
        for (int k = 0; k < 2; k++) begin
            directed(k);
            check_counters(k);
            random_run(k);
            check_counters(k);
        end
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule